// File: doc/BRIEF.md
# TLB Address Translation Unit

This block turns a 32-bit virtual address from a processor's load or store into a physical address, using a small fully associative translation buffer. For each request it checks the alignment of the access against its size and whether the address is permitted in user mode. It then either passes the address through untranslated or looks it up in the buffer. The result is a physical address and a three-bit exception code, available in the same cycle as the request. When a request faults, the faulting address is recorded on the next clock edge. Translation faults also record the faulting page number, so that software can refill the buffer.

The address space has a fixed layout. Addresses whose two top bits are both set bypass the buffer. Addresses with bit 31 set are refused in user mode. Every other address is translated through 4 KiB pages. Software owns four registers: an index, an entry-high register holding a page number, an entry-low register holding a frame number with write and valid flags, and a bad-address register. A one-cycle strobe copies entry-high and entry-low into the buffer entry that the index selects. A missing translation only raises an exception; there is no hardware page-table walk.

Top module: `tlb_mmu`

## Requirements
- R1: With size encoding 00 byte, 01 halfword and 1x word, a word request with either of address bits 1:0 set, or a halfword request with bit 0 set, returns code 1 (illegal address); a byte request never returns code 1.
- R2: A misaligned request loads the bad-address register with the virtual address and leaves entry-high unchanged, even when the address would also miss the buffer.
- R3: A user-mode request with address bit 31 set that is aligned returns code 2 (privileged address) and loads the bad-address register with the virtual address.
- R4: An aligned request to an address with bits 31:30 equal to 11, outside user mode, returns code 0 and physical address {2'b00, addr[29:0]}, whatever the buffer contents.
- R5: Any other request compares address bits 31:12 with the page number of every entry, whether or not the entry is valid; when no entry matches it returns code 3 (miss).
- R6: The lowest-numbered matching entry is used. If its valid flag is clear the code is 4 (invalid); if it is valid, its write flag is clear and the request is a store, the code is 5 (write-protected).
- R7: Codes 3, 4 and 5 load the bad-address register with the full virtual address and entry-high with the page number in bits 31:12, with bits 11:0 zero.
- R8: Faults take priority in the order: alignment, privilege, miss, invalid, write.
- R9: A request that hits without a fault returns code 0 and physical address {frame, addr[11:0]}; on any fault the physical address is zero.
- R10: With register select 0 index, 1 entry-high, 2 entry-low, 3 bad-address, a register write keeps only bits 4:0 of the index, bits 31:12 of entry-high, and bits 31:12, 1 (write) and 0 (valid) of entry-low; bad-address keeps all 32 bits. All other bits read back as zero.
- R11: A pulse on the entry-load strobe writes the entry chosen by the index with the page from entry-high and the frame, write and valid flags from entry-low; the new contents take effect from the next cycle.
- R12: After reset all four registers read zero and every entry holds page 0 with valid clear, so a supervisor access to page 0 returns code 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 32 | Virtual address |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_write | input | 1 | Request is a store |
| req_user | input | 1 | Request comes from user mode |
| resp_paddr | output | 32 | Physical address; zero on a fault |
| resp_exc | output | 3 | 0 none, 1 illegal, 2 privileged, 3 miss, 4 invalid, 5 write |
| reg_sel | input | 2 | Register select: 0 index, 1 entry-high, 2 entry-low, 3 bad-address |
| reg_wr | input | 1 | Write reg_wdata to the selected register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the selected register |
| tlb_load | input | 1 | Copy entry-high and entry-low into the indexed entry |

## Verification
The case that is hardest to reach is the selection among several entries that share one page number while their valid and write flags differ, because only the lowest-numbered match may decide the outcome. The random phase draws page numbers for all entries from a narrow range, so duplicate pages arise often. It then aims most requests at pages that are already loaded, with random sizes, store flags and privilege. A bench model chooses the lowest matching entry and checks the result. Directed requests cover the fault-priority overlaps, such as a misaligned user access to a privileged address, and the masking of the register fields.

// File: rtl/tlb_mmu.sv
module tlb_mmu #(
  parameter int ENTRIES = 32,
  parameter int OFS_W   = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic        req_write,
  input  logic        req_user,
  output logic [31:0] resp_paddr,
  output logic [2:0]  resp_exc,
  input  logic [1:0]  reg_sel,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tlb_load
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int PG_W  = 32 - OFS_W;
  localparam logic [2:0] X_NONE = 3'd0, X_ALIGN = 3'd1, X_PRIV = 3'd2,
                         X_MISS = 3'd3, X_INV = 3'd4, X_WP = 3'd5;
  localparam logic [31:0] LO_MASK = {{PG_W{1'b1}}, {(OFS_W-2){1'b0}}, 2'b11};
  localparam logic [31:0] HI_MASK = {{PG_W{1'b1}}, {OFS_W{1'b0}}};

  logic [PG_W-1:0]  e_page  [ENTRIES];
  logic [PG_W-1:0]  e_frame [ENTRIES];
  logic [ENTRIES-1:0] e_w, e_v, match;

  logic [IDX_W-1:0] r_index;
  logic [31:0]      r_hi, r_lo, r_bad;

  wire [PG_W-1:0]  va_page  = req_addr[31:OFS_W];
  wire [OFS_W-1:0] va_ofs   = req_addr[OFS_W-1:0];
  wire misal  = req_size[1] ? (req_addr[1:0] != 2'b00)
                            : (req_size[0] & req_addr[0]);
  wire priv   = req_user & req_addr[31];
  wire bypass = &req_addr[31:30];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = (e_page[g] == va_page);
  end

  logic             hit;
  logic [IDX_W-1:0] hidx;
  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) begin
        hit  = 1'b1;
        hidx = i[IDX_W-1:0];
      end
  end

  always_comb begin
    resp_exc   = X_NONE;
    resp_paddr = '0;
    if (misal)                          resp_exc = X_ALIGN;
    else if (priv)                      resp_exc = X_PRIV;
    else if (bypass)                    resp_paddr = {2'b00, req_addr[29:0]};
    else if (!hit)                      resp_exc = X_MISS;
    else if (!e_v[hidx])                resp_exc = X_INV;
    else if (!e_w[hidx] && req_write)   resp_exc = X_WP;
    else                                resp_paddr = {e_frame[hidx], va_ofs};
  end

  always_comb
    case (reg_sel)
      2'd0:    reg_rdata = {{(32-IDX_W){1'b0}}, r_index};
      2'd1:    reg_rdata = r_hi;
      2'd2:    reg_rdata = r_lo;
      default: reg_rdata = r_bad;
    endcase

  wire fault    = req_valid && (resp_exc != X_NONE);
  wire tlbfault = fault && (resp_exc >= X_MISS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_index <= '0;
      r_hi    <= '0;
      r_lo    <= '0;
      r_bad   <= '0;
      e_w     <= '0;
      e_v     <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_page[i]  <= '0;
        e_frame[i] <= '0;
      end
    end else begin
      if (reg_wr)
        case (reg_sel)
          2'd0:    r_index <= reg_wdata[IDX_W-1:0];
          2'd1:    r_hi    <= reg_wdata & HI_MASK;
          2'd2:    r_lo    <= reg_wdata & LO_MASK;
          default: r_bad   <= reg_wdata;
        endcase
      if (fault)    r_bad <= req_addr;
      if (tlbfault) r_hi  <= {va_page, {OFS_W{1'b0}}};
      if (tlb_load) begin
        e_page[r_index]  <= r_hi[31:OFS_W];
        e_frame[r_index] <= r_lo[31:OFS_W];
        e_w[r_index]     <= r_lo[1];
        e_v[r_index]     <= r_lo[0];
      end
    end
  end

  a_r1_word_align: assert property (@(posedge clk) disable iff (!rst_n)
    (req_size[1] && req_addr[1:0] != 2'b00) |-> resp_exc == 3'd1);
  a_r1_byte_never: assert property (@(posedge clk) disable iff (!rst_n)
    (req_size == 2'b00) |-> resp_exc != 3'd1);
  a_r3_user_priv: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_exc != 3'd1 && req_user && req_addr[31]) |-> resp_exc == 3'd2);
  a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_exc != 3'd1 && !req_user && &req_addr[31:30])
      |-> (resp_exc == 3'd0 && resp_paddr == {2'b00, req_addr[29:0]}));
  a_r9_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_exc != 3'd0) |-> resp_paddr == 32'd0);
  a_r7_bad_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && resp_exc != 3'd0) |=> r_bad == $past(req_addr));
  a_r7_hi_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && resp_exc >= 3'd3) |=> r_hi == {$past(req_addr[31:OFS_W]), {OFS_W{1'b0}}});
  a_r10_lo_clean: assert property (@(posedge clk) disable iff (!rst_n)
    r_lo[OFS_W-1:2] == '0);
endmodule

// File: tb/tb_tlb_mmu.sv
module tb_tlb_mmu;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0, req_user = 0, reg_wr = 0, tlb_load = 0;
  logic [31:0] req_addr = 0, reg_wdata = 0;
  logic [1:0]  req_size = 0, reg_sel = 0;
  logic [31:0] resp_paddr, reg_rdata;
  logic [2:0]  resp_exc;

  tlb_mmu dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [19:0] m_page [N];
  logic [19:0] m_frame[N];
  logic        m_w[N], m_v[N];
  logic [4:0]  m_idx;
  logic [31:0] m_hi, m_lo, m_bad;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_exc(logic [31:0] a, logic [1:0] s, logic w, logic u);
    int h;
    if (s[1] ? (a[1:0] != 0) : (s[0] & a[0])) return 3'd1;
    if (u && a[31]) return 3'd2;
    if (a[31:30] == 2'b11) return 3'd0;
    h = -1;
    for (int i = N - 1; i >= 0; i--) if (m_page[i] == a[31:12]) h = i;
    if (h < 0) return 3'd3;
    if (!m_v[h]) return 3'd4;
    if (!m_w[h] && w) return 3'd5;
    return 3'd0;
  endfunction

  function automatic logic [31:0] exp_pa(logic [31:0] a, logic [1:0] s, logic w, logic u);
    if (exp_exc(a, s, w, u) != 0) return 32'd0;
    if (a[31:30] == 2'b11) return {2'b00, a[29:0]};
    for (int i = 0; i < N; i++) if (m_page[i] == a[31:12]) return {m_frame[i], a[11:0]};
    return 32'd0;
  endfunction

  function automatic logic [31:0] rd_model(logic [1:0] s);
    case (s)
      2'd0: return {27'd0, m_idx};
      2'd1: return m_hi;
      2'd2: return m_lo;
      default: return m_bad;
    endcase
  endfunction

  task automatic rd_check(string req, logic [1:0] s);
    reg_sel = s;
    #1;
    chk(req, reg_rdata, rd_model(s));
  endtask

  task automatic sw_write(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
    case (s)
      2'd0: m_idx = d[4:0];
      2'd1: m_hi  = d & 32'hFFFFF000;
      2'd2: m_lo  = d & 32'hFFFFF003;
      default: m_bad = d;
    endcase
  endtask

  task automatic load_entry(int i, logic [19:0] pg, logic [19:0] fr, logic w, logic v);
    sw_write(2'd0, i);
    sw_write(2'd1, {pg, 12'h0});
    sw_write(2'd2, {fr, 10'h0, w, v});
    tlb_load = 1;
    @(negedge clk);
    tlb_load = 0;
    m_page[i] = pg; m_frame[i] = fr; m_w[i] = w; m_v[i] = v;
  endtask

  task automatic access(string req, logic [31:0] a, logic [1:0] s, logic w, logic u);
    logic [2:0] e;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_size = s; req_write = w; req_user = u;
    #1;
    e = exp_exc(a, s, w, u);
    chk({req, " exc"}, {29'd0, resp_exc}, {29'd0, e});
    chk({req, " paddr"}, resp_paddr, exp_pa(a, s, w, u));
    @(negedge clk);
    req_valid = 0;
    if (e != 0) m_bad = a;
    if (e >= 3) m_hi = {a[31:12], 12'h0};
    rd_check({req, " bad"}, 2'd3);
    rd_check({req, " hi"}, 2'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin m_page[i] = 0; m_frame[i] = 0; m_w[i] = 0; m_v[i] = 0; end
    m_idx = 0; m_hi = 0; m_lo = 0; m_bad = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    for (int s = 0; s < 4; s++) rd_check("R12 reset reg", s[1:0]);
    access("R12 page0 invalid", 32'h0000_0124, 2'b10, 0, 0);
    // R10 register masking
    sw_write(2'd2, 32'hFFFF_FFFF); rd_check("R10 lo mask", 2'd2);
    sw_write(2'd1, 32'hFFFF_FFFF); rd_check("R10 hi mask", 2'd1);
    sw_write(2'd0, 32'hFFFF_FFFF); rd_check("R10 index mask", 2'd0);
    sw_write(2'd3, 32'h1234_5677); rd_check("R10 bad full", 2'd3);
    // R11 / R9 load and translate
    load_entry(5, 20'h00042, 20'hABCDE, 1, 1);
    access("R9 hit store", 32'h0004_2FFC, 2'b10, 1, 1);
    access("R1 byte odd ok", 32'h0004_2003, 2'b00, 0, 0);
    access("R1 half odd", 32'h0004_2003, 2'b01, 0, 0);
    access("R2 misalign miss", 32'h0777_7002, 2'b11, 0, 0);
    access("R8 align over priv", 32'h8000_0001, 2'b10, 0, 1);
    access("R3 user priv", 32'h8000_0000, 2'b10, 0, 1);
    access("R3 user unmapped", 32'hC000_0010, 2'b00, 0, 1);
    access("R4 bypass", 32'hF123_4568, 2'b10, 1, 0);
    access("R5 miss", 32'h0005_5000, 2'b01, 0, 0);
    // R6 lowest index wins
    load_entry(2, 20'h00077, 20'h11111, 0, 1);
    load_entry(9, 20'h00077, 20'h22222, 1, 1);
    access("R6 write protect", 32'h0007_7010, 2'b10, 1, 0);
    access("R6 low idx read", 32'h0007_7010, 2'b10, 0, 0);
    load_entry(1, 20'h00077, 20'h33333, 1, 0);
    access("R6 invalid first", 32'h0007_7010, 2'b10, 0, 0);
    access("R7 hi on fault", 32'h0007_7abc, 2'b00, 1, 1);
    // random phase
    for (int i = 0; i < N; i++)
      load_entry(i, 20'($urandom % 48), 20'($urandom), 1'($urandom), 1'($urandom % 4 != 0));
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      int m;
      m = $urandom % 8;
      a = $urandom;
      if (m < 5) a = {m_page[$urandom % N], a[11:0]};
      else if (m == 5) a[31:30] = 2'b11;
      else if (m == 6) a = {12'h0, 20'($urandom % 64) , a[11:0]} << 0;
      if (m == 6) a = {20'($urandom % 64), a[11:0]};
      access("R8 random", a, 2'($urandom), 1'($urandom), 1'($urandom % 4 == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule